// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It runs exactly one register access to a debug port or an access port of a target. The user presents the port select, the read/write direction, two register address bits and, for a write, a 32-bit word, then pulses `start`. The engine assembles the request packet and sends it. It releases the data line for the turnaround and collects the target's three-bit acknowledge. On success it moves the data word in the requested direction with a parity bit and closes the access with idle clocks. The result comes back as a status code with a one-cycle `done` pulse. For a read, the received word is also returned.

When the target answers that it is busy, the engine re-issues the whole request by itself. It keeps doing so until a fixed attempt budget runs out. The serial clock is produced from the system clock. Each half-period lasts a programmable number of system clocks, taken once at `start`. The data line is driven through a separate output value and output enable, and is read back on its own input pin.

Top module: `swd_host_engine`

## Requirements
- R1: The request is eight bits sent least significant bit first: a 1, the port select, the read flag, address bit 2, address bit 3, even parity of those four bits, a 0, then a 1. A register-0 debug-port read therefore sends the byte 0xA5.
- R2: After the request the host drives no data for one clock. It then captures three acknowledge bits, first bit least significant, each taken at the end of the clock's low half.
- R3: Acknowledge 3'b001 is success and 3'b100 gives status 1 (fault). Any value other than 3'b001, 3'b010 and 3'b100 gives status 3 (no connection), 3'b111 from an undriven line included.
- R4: Every acknowledge other than 3'b001 is followed by one extra clock with the data line released, before the host retries or finishes.
- R5: Acknowledge 3'b010 restarts the request phase. At most INNER_RETRY*OUTER_RETRY attempts are made in total. If the last allowed attempt also returns 3'b010, the status is 2 (timeout).
- R6: A successful write sends one released turnaround clock, then the 32 data bits least significant first, then their even parity bit, then IDLE_BITS clocks with the line driven low.
- R7: A successful read captures 32 data bits and a parity bit. The word appears on `rdData`, and the status is 0 when the 33 bits have even parity and 4 otherwise. IDLE_BITS low driven clocks follow.
- R8: Outside a transaction `swclk` is high and `swdioOe` is low.
- R9: Each low half and each high half of `swclk` lasts max(bitDelay,1) system clocks. The value used is the one present at `start`; later changes to `bitDelay` have no effect on the running transaction.
- R10: `done` is high for one cycle, together with the final `status`. `busy` is high from the cycle after an accepted start until `done`.
- R11: A `start` pulse while `busy` is high is ignored. It does not change the request on the wire and does not cause a second transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| reqAp | input | 1 | 1 selects access port, 0 debug port |
| reqRnw | input | 1 | 1 read, 0 write |
| reqAddr | input | 2 | Register address bits 3:2 |
| wrData | input | 32 | Word to write |
| bitDelay | input | DIV_W | System clocks per serial half-period |
| swdioIn | input | 1 | Sampled data line |
| swclk | output | 1 | Serial clock |
| swdioOut | output | 1 | Data line drive value |
| swdioOe | output | 1 | Data line output enable |
| rdData | output | 32 | Word read from the target |
| status | output | 3 | 0 OK, 1 fault, 2 timeout, 3 no connection, 4 parity error |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Transaction in progress |

## Verification
The bench plays the target at bit level. It sweeps all sixteen request encodings across several clock divisors, and it also counts the low system cycles of `swclk`. A divisor of zero or a missed latch then shows up as a wrong count. The budget is probed at both edges: one WAIT fewer than the limit must still succeed, and exactly the limit must time out. An off-by-one counter would turn one of those into the other. Other cases cover a WAIT followed by FAULT, unknown acknowledges including a floating line, a corrupted read parity, and a start pulse issued mid-transfer. A design that skipped the extra turnaround, changed its request, or ran twice would lose step with the target model and be reported.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  localparam int WORD_W = 32;
  localparam int REQ_W  = 8;
  localparam int ACK_W  = 3;

  localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_FAULT   = 3'd1,
    ST_TIMEOUT = 3'd2,
    ST_NOCONN  = 3'd3,
    ST_PARITY  = 3'd4
  } xferStat_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_REQ, PH_TRN, PH_ACK, PH_TRNX,
    PH_WTRN, PH_WDAT, PH_RDAT, PH_IDL8
  } busPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startLatch;
    logic loadReq;
    logic loadWr;
    logic shiftTx;
    logic capAck;
    logic capRx;
    logic run;
  } dpCtl_t;

  function automatic logic [REQ_W-1:0] encReq(input logic ap, input logic rnw,
                                              input logic [1:0] addr);
    return {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_host_dp.sv
module swd_host_dp
  import swd_host_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqAp,
  input  logic              reqRnw,
  input  logic [1:0]        reqAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [DIV_W-1:0]  bitDelay,
  input  logic              swdioIn,
  output logic              halfTick,
  output logic              txBit,
  output logic              isRead,
  output logic [ACK_W-1:0]  ackVal,
  output logic              rxParOk,
  output logic [WORD_W-1:0] rdData
);

  localparam int FRAME_W = WORD_W + 1;

  logic [DIV_W-1:0]   divLat, halfCnt, lastCnt;
  logic [REQ_W-1:0]   reqByte;
  logic [WORD_W-1:0]  wrLat;
  logic [FRAME_W-1:0] txShift, rxShift;
  logic [ACK_W-1:0]   ackShift;

  assign lastCnt  = (divLat == '0) ? '0 : divLat - 1'b1;
  assign halfTick = ctl.run && (halfCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLat   <= '0;
      halfCnt  <= '0;
      reqByte  <= '0;
      wrLat    <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      ackShift <= '0;
    end else if (ctl.startLatch) begin
      divLat  <= bitDelay;
      halfCnt <= '0;
      reqByte <= encReq(reqAp, reqRnw, reqAddr);
      wrLat   <= wrData;
      txShift <= {{(FRAME_W-REQ_W){1'b0}}, encReq(reqAp, reqRnw, reqAddr)};
    end else begin
      if (ctl.run) halfCnt <= halfTick ? '0 : halfCnt + 1'b1;
      if (ctl.loadReq)      txShift <= {{(FRAME_W-REQ_W){1'b0}}, reqByte};
      else if (ctl.loadWr)  txShift <= {^wrLat, wrLat};
      else if (ctl.shiftTx) txShift <= {1'b0, txShift[FRAME_W-1:1]};
      if (ctl.capAck) ackShift <= {swdioIn, ackShift[ACK_W-1:1]};
      if (ctl.capRx)  rxShift  <= {swdioIn, rxShift[FRAME_W-1:1]};
    end
  end

  assign txBit   = txShift[0];
  assign isRead  = reqByte[2];
  assign ackVal  = ackShift;
  assign rxParOk = ~^rxShift;
  assign rdData  = rxShift[WORD_W-1:0];

  // R9
  half_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> halfCnt <= lastCnt);

  // R6
  wr_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWr |=> (^txShift) == 1'b0);

endmodule

// File: rtl/swd_host_ctrl.sv
module swd_host_ctrl
  import swd_host_pkg::*;
#(
  parameter int INNER_RETRY = 250,
  parameter int OUTER_RETRY = 8,
  parameter int IDLE_BITS   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             halfTick,
  input  logic             txBit,
  input  logic             isRead,
  input  logic [ACK_W-1:0] ackVal,
  input  logic             rxParOk,
  output dpCtl_t           ctl,
  output logic             swclk,
  output logic             swdioOut,
  output logic             swdioOe,
  output logic             busy,
  output logic             done,
  output logic [2:0]       status
);

  localparam int MAXB  = (WORD_W + 1 > IDLE_BITS) ? WORD_W + 1 : IDLE_BITS;
  localparam int BIT_W = $clog2(MAXB);
  localparam int IN_W  = (INNER_RETRY > 1) ? $clog2(INNER_RETRY) : 1;
  localparam int OUT_W = (OUTER_RETRY > 1) ? $clog2(OUTER_RETRY) : 1;

  busPhase_e        state;
  logic             phase;
  logic [BIT_W-1:0] bitCnt, lastBit;
  logic [IN_W-1:0]  innerCnt;
  logic [OUT_W-1:0] outerCnt;
  logic             retryPend, doneReg;
  xferStat_e        pendStat, statusReg;
  logic             lowEnd, highEnd, bitLast, innerLast, budgetOut;

  assign lowEnd    = halfTick & ~phase;
  assign highEnd   = halfTick & phase;
  assign bitLast   = (bitCnt == lastBit);
  assign innerLast = (innerCnt == IN_W'(INNER_RETRY - 1));
  assign budgetOut = innerLast && (outerCnt == OUT_W'(OUTER_RETRY - 1));

  always_comb begin
    unique case (state)
      PH_REQ:           lastBit = BIT_W'(REQ_W - 1);
      PH_ACK:           lastBit = BIT_W'(ACK_W - 1);
      PH_WDAT, PH_RDAT: lastBit = BIT_W'(WORD_W);
      PH_IDL8:          lastBit = BIT_W'(IDLE_BITS - 1);
      default:          lastBit = '0;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.run        = (state != PH_IDLE);
    ctl.startLatch = (state == PH_IDLE) && start;
    ctl.capAck     = lowEnd && (state == PH_ACK);
    ctl.capRx      = lowEnd && (state == PH_RDAT);
    ctl.shiftTx    = highEnd && ((state == PH_REQ) || (state == PH_WDAT));
    ctl.loadWr     = highEnd && (state == PH_WTRN);
    ctl.loadReq    = highEnd && (state == PH_TRNX) && retryPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      phase     <= 1'b0;
      bitCnt    <= '0;
      innerCnt  <= '0;
      outerCnt  <= '0;
      retryPend <= 1'b0;
      pendStat  <= ST_OK;
      statusReg <= ST_OK;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (state == PH_IDLE) begin
        if (start) begin
          state     <= PH_REQ;
          phase     <= 1'b0;
          bitCnt    <= '0;
          innerCnt  <= '0;
          outerCnt  <= '0;
          retryPend <= 1'b0;
        end
      end else if (lowEnd) begin
        phase <= 1'b1;
      end else if (highEnd) begin
        phase <= 1'b0;
        if (!bitLast) begin
          bitCnt <= bitCnt + 1'b1;
        end else begin
          bitCnt <= '0;
          case (state)
            PH_REQ: state <= PH_TRN;
            PH_TRN: state <= PH_ACK;
            PH_ACK: begin
              if (ackVal == ACK_OK) begin
                state <= isRead ? PH_RDAT : PH_WTRN;
              end else begin
                state <= PH_TRNX;
                if (ackVal == ACK_WAIT) begin
                  retryPend <= !budgetOut;
                  pendStat  <= ST_TIMEOUT;
                  if (innerLast) begin
                    innerCnt <= '0;
                    outerCnt <= outerCnt + 1'b1;
                  end else begin
                    innerCnt <= innerCnt + 1'b1;
                  end
                end else begin
                  retryPend <= 1'b0;
                  pendStat  <= (ackVal == ACK_FAULT) ? ST_FAULT : ST_NOCONN;
                end
              end
            end
            PH_TRNX: begin
              if (retryPend) begin
                state <= PH_REQ;
              end else begin
                state     <= PH_IDLE;
                doneReg   <= 1'b1;
                statusReg <= pendStat;
              end
            end
            PH_WTRN: state <= PH_WDAT;
            PH_WDAT: state <= PH_IDL8;
            PH_RDAT: begin
              state    <= PH_IDL8;
              pendStat <= rxParOk ? ST_OK : ST_PARITY;
            end
            PH_IDL8: begin
              state     <= PH_IDLE;
              doneReg   <= 1'b1;
              statusReg <= isRead ? pendStat : ST_OK;
            end
            default: state <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign busy     = (state != PH_IDLE);
  assign swclk    = (state == PH_IDLE) | phase;
  assign swdioOe  = (state == PH_REQ) || (state == PH_WDAT) || (state == PH_IDL8);
  assign swdioOut = ((state == PH_REQ) || (state == PH_WDAT)) & txBit;
  assign done     = doneReg;
  assign status   = statusReg;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R9
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !halfTick) |=> $stable(swclk));

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int INNER_RETRY = 250,
  parameter int OUTER_RETRY = 8,
  parameter int IDLE_BITS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              reqAp,
  input  logic              reqRnw,
  input  logic [1:0]        reqAddr,
  input  logic [31:0]       wrData,
  input  logic [DIV_W-1:0]  bitDelay,
  input  logic              swdioIn,
  output logic              swclk,
  output logic              swdioOut,
  output logic              swdioOe,
  output logic [31:0]       rdData,
  output logic [2:0]        status,
  output logic              done,
  output logic              busy
);

  dpCtl_t           ctl;
  logic             halfTick, txBit, isRead, rxParOk;
  logic [ACK_W-1:0] ackVal;

  swd_host_ctrl #(
    .INNER_RETRY(INNER_RETRY),
    .OUTER_RETRY(OUTER_RETRY),
    .IDLE_BITS  (IDLE_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .halfTick(halfTick),
    .txBit   (txBit),
    .isRead  (isRead),
    .ackVal  (ackVal),
    .rxParOk (rxParOk),
    .ctl     (ctl),
    .swclk   (swclk),
    .swdioOut(swdioOut),
    .swdioOe (swdioOe),
    .busy    (busy),
    .done    (done),
    .status  (status)
  );

  swd_host_dp #(
    .DIV_W(DIV_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAp   (reqAp),
    .reqRnw  (reqRnw),
    .reqAddr (reqAddr),
    .wrData  (wrData),
    .bitDelay(bitDelay),
    .swdioIn (swdioIn),
    .halfTick(halfTick),
    .txBit   (txBit),
    .isRead  (isRead),
    .ackVal  (ackVal),
    .rxParOk (rxParOk),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_swd_host_engine.sv
module sim_swd_host_engine;

  localparam int DIV_W  = 4;
  localparam int INNER  = 3;
  localparam int OUTER  = 2;
  localparam int IDLE_N = 8;
  localparam int BUDGET = INNER * OUTER;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0, reqAp = 1'b0, reqRnw = 1'b0;
  logic [1:0]       reqAddr = '0;
  logic [31:0]      wrData = '0;
  logic [DIV_W-1:0] bitDelay = '0;
  logic             swdioIn = 1'b1;
  wire              swclk, swdioOut, swdioOe, busy, done;
  wire [31:0]       rdData;
  wire [2:0]        status;

  swd_host_engine #(.DIV_W(DIV_W), .INNER_RETRY(INNER), .OUTER_RETRY(OUTER),
                    .IDLE_BITS(IDLE_N)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .reqAp(reqAp), .reqRnw(reqRnw),
    .reqAddr(reqAddr), .wrData(wrData), .bitDelay(bitDelay), .swdioIn(swdioIn),
    .swclk(swclk), .swdioOut(swdioOut), .swdioOe(swdioOe), .rdData(rdData),
    .status(status), .done(done), .busy(busy));

  // target model configuration (written by the stimulus only)
  int          txnId = 0, cfgWaits = 0;
  logic [2:0]  cfgAck = 3'b001;
  logic        cfgAbsent = 1'b0, cfgBadPar = 1'b0;
  logic [31:0] cfgRd = '0;
  logic [7:0]  expReq = '0;
  logic [32:0] rdWord;
  assign rdWord = {(^cfgRd) ^ cfgBadPar, cfgRd};

  // target model state (written by the model only)
  int          seenId = 0, rise = 0, attempts = 0, waitsLeft = 0;
  int          busErr = 0, idleErr = 0, reqErr = 0;
  logic [7:0]  reqCap = '0;
  logic [2:0]  curAck = 3'b001;
  logic [32:0] wrCap = '0;
  logic        rdMode = 1'b0;

  always @(posedge swclk) begin
    if (txnId != seenId) begin
      seenId = txnId; rise = 0; attempts = 0; waitsLeft = cfgWaits;
      busErr = 0; idleErr = 0; reqErr = 0; wrCap = '0;
    end
    rise++;
    if (rise <= 8) begin
      if (rise == 1) attempts++;
      if (!swdioOe) busErr++;
      reqCap[rise-1] = swdioOut;
      if (rise == 8) begin
        if (reqCap != expReq) reqErr++;
        rdMode = reqCap[2];
      end
    end else if (rise == 9) begin
      if (swdioOe) busErr++;
      if (waitsLeft > 0) begin curAck = 3'b010; waitsLeft--; end
      else curAck = cfgAck;
    end else if (rise <= 12) begin
      if (swdioOe) busErr++;
    end else if (curAck != 3'b001) begin
      if (swdioOe) busErr++;   // extra released clock, then a new attempt
      rise = 0;
    end else if (!rdMode) begin
      if (rise == 13) begin
        if (swdioOe) busErr++;
      end else if (rise <= 46) begin
        if (!swdioOe) busErr++;
        wrCap[rise-14] = swdioOut;
      end else if (rise <= 46 + IDLE_N) begin
        if (!swdioOe || swdioOut) idleErr++;
      end else busErr++;
    end else begin
      if (rise <= 45) begin
        if (swdioOe) busErr++;
      end else if (rise <= 45 + IDLE_N) begin
        if (!swdioOe || swdioOut) idleErr++;
      end else busErr++;
    end
  end

  always @(negedge swclk) begin
    if (cfgAbsent || txnId != seenId) swdioIn = 1'b1;
    else if (rise >= 9 && rise <= 11) swdioIn = curAck[rise-9];
    else if (rdMode && curAck == 3'b001 && rise >= 12 && rise <= 44) swdioIn = rdWord[rise-12];
    else swdioIn = 1'b1;
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic runTxn(input logic ap, input logic rnw, input logic [1:0] addr,
                        input logic [31:0] wd, input int dly, input int waits,
                        input logic [2:0] ack, input logic absent, input logic badPar,
                        input logic [31:0] rdv, input bit poke);
    int lowCyc = 0, cyc = 0, att, finalBits, lowExp, expStat;
    bit seenDone = 0;
    logic finalOk;
    cfgWaits = waits; cfgAck = absent ? 3'b111 : ack; cfgAbsent = absent;
    cfgBadPar = badPar; cfgRd = rdv;
    expReq = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    txnId++;
    if (waits >= BUDGET) begin att = BUDGET; expStat = 2; finalOk = 0; end
    else begin
      att = waits + 1;
      finalOk = (cfgAck == 3'b001);
      if (finalOk) expStat = (rnw && badPar) ? 4 : 0;
      else if (cfgAck == 3'b100) expStat = 1;
      else expStat = 3;
    end
    finalBits = finalOk ? (rnw ? 45 + IDLE_N : 46 + IDLE_N) : 13;
    lowExp = ((att - 1) * 13 + finalBits) * ((dly == 0) ? 1 : dly);
    @(negedge clk);
    reqAp = ap; reqRnw = rnw; reqAddr = addr; wrData = wd;
    bitDelay = DIV_W'(dly); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bitDelay = DIV_W'(dly) ^ '1;   // R9: must not affect the running access
    while (!seenDone && cyc < 20000) begin
      if (!swclk) lowCyc++;
      if (done) begin
        seenDone = 1;
        chk(status == 3'(expStat), "R3 R5 R7", "status", status, expStat);
      end
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin
        start = 1'b1; reqAp = ~ap; reqRnw = ~rnw; reqAddr = ~addr;
      end else start = 1'b0;
    end
    chk(seenDone, "R10", "watchdog done seen", seenDone, 1);
    chk(!done, "R10", "done single cycle", done, 0);
    chk(swclk && !swdioOe, "R8", "rest state clk/oe", {swclk, swdioOe}, 2);
    chk(lowCyc == lowExp, "R9", "swclk low cycles", lowCyc, lowExp);
    chk(attempts == att, "R5", "request attempts", attempts, att);
    chk(reqErr == 0, "R1", "request byte mismatches", reqErr, 0);
    chk(busErr == 0, "R2 R4", "bus direction/length errors", busErr, 0);
    if (finalOk) chk(idleErr == 0, "R6 R7", "idle clock errors", idleErr, 0);
    if (finalOk && !rnw)
      chk(wrCap == {^wd, wd}, "R6", "write frame", wrCap, {^wd, wd});
    if (finalOk && rnw && !badPar)
      chk(rdData == rdv, "R7", "read word", rdData, rdv);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(!busy, "R11", "no second transaction", busy, 0);
      chk(attempts == 1, "R11", "attempts after ignored start", attempts, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
    chk(swclk && !swdioOe, "R8", "reset clk/oe", {swclk, swdioOe}, 2);

    // sweep every request encoding, both directions, divisors 0..2
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w;
      w = 32'hA5A5_0000 ^ (32'(i) * 32'h0103_0507) ^ (32'h1 << (i * 2));
      runTxn(i[0], i[1], i[3:2], w, i % 3, 0, 3'b001, 0, 0, ~w, 0);
    end

    // R1: debug-port register 0 read encodes as 0xA5
    runTxn(0, 1, 2'b00, 0, 3, 0, 3'b001, 0, 0, 32'h1BA0_1477, 0);
    chk(reqCap == 8'hA5, "R1", "IDCODE request byte", reqCap, 8'hA5);

    // R5: budget edges
    runTxn(1, 1, 2'b01, 0, 1, BUDGET - 1, 3'b001, 0, 0, 32'hCAFE_F00D, 0);
    runTxn(1, 0, 2'b10, 32'h1234_5678, 2, BUDGET, 3'b001, 0, 0, 0, 0);
    // R3 R4: wait then fault, direct fault, unknown acknowledges
    runTxn(0, 0, 2'b11, 32'hFFFF_FFFF, 1, 2, 3'b100, 0, 0, 0, 0);
    runTxn(1, 1, 2'b00, 0, 0, 0, 3'b100, 0, 0, 0, 0);
    runTxn(0, 1, 2'b01, 0, 2, 0, 3'b000, 0, 0, 0, 0);
    runTxn(0, 1, 2'b10, 0, 1, 0, 3'b011, 0, 0, 0, 0);
    runTxn(1, 0, 2'b01, 32'h0F0F_0F0F, 1, 0, 3'b110, 0, 0, 0, 0);
    runTxn(1, 0, 2'b11, 32'h8000_0001, 1, 0, 3'b101, 0, 0, 0, 0);
    runTxn(0, 1, 2'b00, 0, 2, 0, 3'b001, 1, 0, 0, 0);
    // R7: corrupted parity, then a clean read
    runTxn(1, 1, 2'b11, 0, 1, 0, 3'b001, 0, 1, 32'h0000_0007, 0);
    runTxn(1, 1, 2'b11, 0, 1, 0, 3'b001, 0, 0, 32'h8000_0000, 0);
    // R11: start during a transfer
    runTxn(0, 0, 2'b01, 32'h5555_AAAA, 2, 0, 3'b001, 0, 0, 0, 1);
    // R9: largest divisor
    runTxn(1, 0, 2'b10, 32'h0000_0000, 15, 0, 3'b001, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule